// File: doc/BRIEF.md
# Page-Table Entry Access/Dirty Flag Updater

This block sits at the leaf step of a page-table walker. When the walker reaches a leaf entry whose accessed flag is clear, or whose dirty flag is clear on a store, the block sets the flag in memory. It first checks that the governing enable is on and that a write to the entry would be permitted. It then issues one atomic compare-and-swap for the entry. The compare value is the entry the walker holds, and the swap value is that entry with the needed flags set.

The block returns one of four results to the walker:
- the entry is usable as is;
- the walk must restart from its first lookup, because memory no longer held the expected entry;
- a page fault;
- an access fault, tagged with the original access type.

The block also holds the two enable bits: a machine-level enable for single-stage and guest-stage translation, and a hypervisor-level enable for VS-stage translation. Both sit at bit 61 of their 64-bit configuration words.

A speculative store that needs a dirty update is held back until the walker signals commit. Accessed-only updates go out at once, speculative or not. A result is only reported after the memory port has acknowledged the swap, so the original access cannot be released before the entry write is visible.

Top module: `pte_ad_updater`

## Requirements
- R1: With the accessed flag (entry bit 6) set, and either a non-store access or the dirty flag (entry bit 7) set, the result is done (code 0). `rsp_pte` equals the request entry. No memory request is made. `rsp_valid` is high in the first cycle after the request is accepted.
- R2: When an update is needed and the governing enable is 0, the result is page fault (code 2) with no memory request. Access types are load 0, store 1, fetch 2.
- R3: Stage 0 (single) and stage 1 (guest) are governed by the machine-level enable. Stage 2 (VS) is governed by the hypervisor-level enable.
- R4: When an update is needed, the enable is on and `req_store_ok` is 0, the result is access fault (code 3). `rsp_acc` equals the request access type. No memory request is made.
- R5: A swap request carries the entry address, the request entry as compare value, and a swap value equal to the entry with bit 6 set, plus bit 7 when the access is a store. `mem_req` and its fields hold steady until `mem_gnt`.
- R6: A swap response whose returned old value equals the compare value, and that has no error, gives done, with `rsp_pte` equal to the swap value. The result appears only in the cycle after `mem_rsp_valid`.
- R7: A swap response whose old value differs from the compare value gives restart (code 1), with `rsp_pte` equal to the request entry.
- R8: A swap response with `mem_rsp_err` set gives access fault (code 3), with `rsp_acc` equal to the original access type.
- R9: A speculative store that needs an update issues no memory request before `commit`. Speculative loads and fetches issue the swap without waiting.
- R10: Only bit 61 of each enable word is stored, and all other bits read 0. Both words reset to 0. The hypervisor-level enable reads 0 while the machine-level enable is 0. Writing the machine-level enable to 0 clears the hypervisor-level enable.
- R11: `busy` is high from the accepted request through the result cycle. `rsp_valid` lasts one cycle. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| env_m_we | input | 1 | Write strobe, machine-level enable word |
| env_h_we | input | 1 | Write strobe, hypervisor-level enable word |
| env_wdata | input | 64 | Write data for either enable word |
| env_m_rdata | output | 64 | Read value, machine-level enable word |
| env_h_rdata | output | 64 | Read value, hypervisor-level enable word |
| req_valid | input | 1 | Update request strobe, taken when idle |
| req_pte | input | 64 | Leaf entry value held by the walker |
| req_addr | input | 56 | Physical address of the leaf entry |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| req_stage | input | 2 | Stage: 0 single, 1 guest, 2 VS |
| req_spec | input | 1 | Request is speculative |
| req_store_ok | input | 1 | Store permission/attribute check on the entry passed |
| commit | input | 1 | Held speculative store is now non-speculative |
| busy | output | 1 | Request in progress |
| mem_req | output | 1 | Atomic compare-and-swap request |
| mem_addr | output | 56 | Swap address |
| mem_cmp | output | 64 | Compare value |
| mem_swap | output | 64 | Value written on a match |
| mem_gnt | input | 1 | Request granted |
| mem_rsp_valid | input | 1 | Swap complete and visible |
| mem_rsp_old | input | 64 | Value memory held before the swap |
| mem_rsp_err | input | 1 | Bus error on the swap |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_code | output | 2 | 0 done, 1 restart, 2 page fault, 3 access fault |
| rsp_acc | output | 2 | Access type of the request |
| rsp_pte | output | 64 | Resulting entry value |

## Verification
Results that need no memory (pass, page fault, access fault) are due in the first cycle after the accepting edge. Swap results are due exactly one cycle after the cycle in which the bench raises `mem_rsp_valid`. The bench records the cycle index of each stimulus it drives and accepts `rsp_valid` only at that predicted index. A response in any other cycle is counted as a failure. A held speculative store is checked by recording the cycle in which `commit` is driven and flagging any `mem_req` seen before the following cycle.

// File: rtl/pte_ad_pkg.sv
// Shared encodings for the access/dirty updater.
// Assumes two-bit codes on the ports; values are fixed by the requirements.
package pte_ad_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        STG_SINGLE = 2'd0,
        STG_GUEST  = 2'd1,
        STG_VS     = 2'd2
    } stage_e;

    typedef enum logic [1:0] {
        RES_DONE    = 2'd0,
        RES_RESTART = 2'd1,
        RES_PFAULT  = 2'd2,
        RES_AFAULT  = 2'd3
    } res_e;

    // Action chosen when a request is accepted.
    typedef enum logic [1:0] {
        ACT_PASS  = 2'd0,
        ACT_FAULT = 2'd1,
        ACT_HOLD  = 2'd2,
        ACT_SWAP  = 2'd3
    } act_e;

endpackage

// File: rtl/ad_env_regs.sv
// Holds the machine-level and hypervisor-level update enables.
// Assumes both words share one write data bus; when both strobes are
// high in one cycle the hypervisor enable is qualified by the new machine
// enable. Only one bit of each word is stored.
module ad_env_regs #(
    parameter int XLEN      = 64,
    parameter int EN_BIT    = 61,
    parameter bit SUPPORTED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            m_we,
    input  logic            h_we,
    input  logic [XLEN-1:0] wdata,
    output logic            m_en,
    output logic            h_en,
    output logic [XLEN-1:0] m_rdata,
    output logic [XLEN-1:0] h_rdata
);
    logic m_q, h_q;
    logic m_next, h_next;

    // Next values: hypervisor enable can never outlive the machine enable.
    always_comb begin
        m_next = m_we ? (SUPPORTED & wdata[EN_BIT]) : m_q;
        h_next = (h_we ? (SUPPORTED & wdata[EN_BIT]) : h_q) & m_next;
    end

    // Enable storage with synchronous reset to disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= 1'b0;
            h_q <= 1'b0;
        end else begin
            m_q <= m_next;
            h_q <= h_next;
        end
    end

    assign m_en    = m_q;
    assign h_en    = h_q;
    assign m_rdata = XLEN'(m_q) << EN_BIT;
    assign h_rdata = XLEN'(h_q) << EN_BIT;

endmodule

// File: rtl/ad_decide.sv
// Combinational decision on an incoming leaf entry: pass, fault, hold
// for commit, or swap. Also forms the swap value.
// Assumes the permission check result is valid with the request.
module ad_decide
    import pte_ad_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int A_BIT = 6,
    parameter int D_BIT = 7
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    input  logic [1:0]       stage,
    input  logic             spec,
    input  logic             store_ok,
    input  logic             m_en,
    input  logic             h_en,
    output act_e             act,
    output res_e             res,
    output logic [PTE_W-1:0] new_pte
);
    localparam logic [PTE_W-1:0] A_MASK = PTE_W'(1) << A_BIT;
    localparam logic [PTE_W-1:0] D_MASK = PTE_W'(1) << D_BIT;

    logic is_store, need, en;

    // Classify the request and pick the action in priority order.
    always_comb begin
        is_store = (acc == ACC_STORE);
        need     = !pte[A_BIT] || (is_store && !pte[D_BIT]);
        en       = (stage == STG_VS) ? h_en : m_en;
        new_pte  = pte | A_MASK | (is_store ? D_MASK : '0);
        res      = RES_DONE;
        if (!need) begin
            act = ACT_PASS;
        end else if (!en) begin
            act = ACT_FAULT;
            res = RES_PFAULT;
        end else if (!store_ok) begin
            act = ACT_FAULT;
            res = RES_AFAULT;
        end else if (is_store && spec) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_SWAP;
        end
    end

endmodule

// File: rtl/ad_cas_seq.sv
// Sequencer: accepts one request at a time, waits for commit when needed,
// runs the compare-and-swap handshake and presents the result for one cycle.
// Assumes memory acknowledges a swap only once it is globally visible.
module ad_cas_seq
    import pte_ad_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int PA_W  = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [PTE_W-1:0] req_pte,
    input  logic [PA_W-1:0]  req_addr,
    input  logic [1:0]       req_acc,
    input  act_e             act,
    input  res_e             res_imm,
    input  logic [PTE_W-1:0] new_pte,
    input  logic             commit,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_cmp,
    output logic [PTE_W-1:0] mem_swap,
    input  logic             mem_gnt,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_old,
    input  logic             mem_rsp_err,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [1:0]       rsp_acc,
    output logic [PTE_W-1:0] rsp_pte
);
    typedef enum logic [2:0] {
        S_IDLE, S_HOLD, S_ISSUE, S_WAIT, S_RESP
    } state_e;

    state_e           state;
    logic [PTE_W-1:0] old_q, new_q, out_q;
    logic [PA_W-1:0]  addr_q;
    logic [1:0]       acc_q;
    res_e             res_q;

    // Request capture, handshake progress and result formation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            old_q  <= '0;
            new_q  <= '0;
            out_q  <= '0;
            addr_q <= '0;
            acc_q  <= '0;
            res_q  <= RES_DONE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    old_q  <= req_pte;
                    new_q  <= new_pte;
                    out_q  <= req_pte;
                    addr_q <= req_addr;
                    acc_q  <= req_acc;
                    res_q  <= res_imm;
                    unique case (act)
                        ACT_PASS, ACT_FAULT: state <= S_RESP;
                        ACT_HOLD:            state <= S_HOLD;
                        ACT_SWAP:            state <= S_ISSUE;
                    endcase
                end
                S_HOLD:  if (commit)  state <= S_ISSUE;
                S_ISSUE: if (mem_gnt) state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    state <= S_RESP;
                    if (mem_rsp_err) begin
                        res_q <= RES_AFAULT;
                    end else if (mem_rsp_old != old_q) begin
                        res_q <= RES_RESTART;
                    end else begin
                        res_q <= RES_DONE;
                        out_q <= new_q;
                    end
                end
                S_RESP:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign mem_req   = (state == S_ISSUE);
    assign mem_addr  = addr_q;
    assign mem_cmp   = old_q;
    assign mem_swap  = new_q;
    assign rsp_valid = (state == S_RESP);
    assign rsp_code  = res_q;
    assign rsp_acc   = acc_q;
    assign rsp_pte   = out_q;

endmodule

// File: rtl/pte_ad_updater.sv
// Top: leaf-entry accessed/dirty updater for a page-table walker.
// Wires the enable registers, the decision logic and the swap sequencer.
// Assumes the walker holds request fields only in the accepting cycle.
module pte_ad_updater
    import pte_ad_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int PTE_W     = 64,
    parameter int PA_W      = 56,
    parameter int A_BIT     = 6,
    parameter int D_BIT     = 7,
    parameter int EN_BIT    = 61,
    parameter bit SUPPORTED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             env_m_we,
    input  logic             env_h_we,
    input  logic [XLEN-1:0]  env_wdata,
    output logic [XLEN-1:0]  env_m_rdata,
    output logic [XLEN-1:0]  env_h_rdata,
    input  logic             req_valid,
    input  logic [PTE_W-1:0] req_pte,
    input  logic [PA_W-1:0]  req_addr,
    input  logic [1:0]       req_acc,
    input  logic [1:0]       req_stage,
    input  logic             req_spec,
    input  logic             req_store_ok,
    input  logic             commit,
    output logic             busy,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_cmp,
    output logic [PTE_W-1:0] mem_swap,
    input  logic             mem_gnt,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_old,
    input  logic             mem_rsp_err,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [1:0]       rsp_acc,
    output logic [PTE_W-1:0] rsp_pte
);
    logic             m_en, h_en;
    act_e             act;
    res_e             res_imm;
    logic [PTE_W-1:0] new_pte;

    ad_env_regs #(
        .XLEN(XLEN), .EN_BIT(EN_BIT), .SUPPORTED(SUPPORTED)
    ) u_env (
        .clk(clk), .rst_n(rst_n),
        .m_we(env_m_we), .h_we(env_h_we), .wdata(env_wdata),
        .m_en(m_en), .h_en(h_en),
        .m_rdata(env_m_rdata), .h_rdata(env_h_rdata)
    );

    ad_decide #(
        .PTE_W(PTE_W), .A_BIT(A_BIT), .D_BIT(D_BIT)
    ) u_decide (
        .pte(req_pte), .acc(req_acc), .stage(req_stage),
        .spec(req_spec), .store_ok(req_store_ok),
        .m_en(m_en), .h_en(h_en),
        .act(act), .res(res_imm), .new_pte(new_pte)
    );

    ad_cas_seq #(
        .PTE_W(PTE_W), .PA_W(PA_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_pte(req_pte), .req_addr(req_addr),
        .req_acc(req_acc), .act(act), .res_imm(res_imm), .new_pte(new_pte),
        .commit(commit), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_cmp(mem_cmp),
        .mem_swap(mem_swap), .mem_gnt(mem_gnt),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_old(mem_rsp_old),
        .mem_rsp_err(mem_rsp_err),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .rsp_acc(rsp_acc), .rsp_pte(rsp_pte)
    );

endmodule

// File: rtl/pte_ad_updater_chk.sv
// Protocol checker for the updater, bound to every instance of the top.
// Observes ports only.
module pte_ad_updater_chk #(
    parameter int XLEN   = 64,
    parameter int PTE_W  = 64,
    parameter int PA_W   = 56,
    parameter int A_BIT  = 6,
    parameter int D_BIT  = 7,
    parameter int EN_BIT = 61
) (
    input logic             clk,
    input logic             rst_n,
    input logic [XLEN-1:0]  env_m_rdata,
    input logic [XLEN-1:0]  env_h_rdata,
    input logic             busy,
    input logic             mem_req,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_cmp,
    input logic [PTE_W-1:0] mem_swap,
    input logic             mem_gnt,
    input logic             rsp_valid
);
    localparam logic [PTE_W-1:0] AD_MASK =
        (PTE_W'(1) << A_BIT) | (PTE_W'(1) << D_BIT);

    // R11: result strobe lasts exactly one cycle
    a_r11_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: a result is only shown while the request is in progress
    a_r11_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    // R10: hypervisor enable never reads set while machine enable is clear
    a_r10_h_follows_m: assert property (@(posedge clk) disable iff (!rst_n)
        !env_m_rdata[EN_BIT] |-> !env_h_rdata[EN_BIT]);

    // R5: swap value sets the accessed flag and differs from compare only in flags
    a_r5_swap_value: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_swap[A_BIT] && ((mem_swap | AD_MASK) == (mem_cmp | AD_MASK))));

    // R5: request and its fields hold until granted
    a_r5_hold_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_swap)));

    // R6: no result while the swap is still being requested
    a_r6_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rsp_valid);

    // R11: memory traffic only while busy
    a_r11_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

bind pte_ad_updater pte_ad_updater_chk #(
    .XLEN(XLEN), .PTE_W(PTE_W), .PA_W(PA_W),
    .A_BIT(A_BIT), .D_BIT(D_BIT), .EN_BIT(EN_BIT)
) u_chk (.*);

// File: tb/pte_ad_updater_test.sv
module pte_ad_updater_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        env_m_we = 0, env_h_we = 0;
    logic [63:0] env_wdata = '0;
    logic [63:0] env_m_rdata, env_h_rdata;
    logic        req_valid = 0;
    logic [63:0] req_pte = '0;
    logic [55:0] req_addr = '0;
    logic [1:0]  req_acc = '0, req_stage = '0;
    logic        req_spec = 0, req_store_ok = 0, commit = 0;
    logic        busy, mem_req;
    logic [55:0] mem_addr;
    logic [63:0] mem_cmp, mem_swap;
    logic        mem_gnt = 0, mem_rsp_valid = 0, mem_rsp_err = 0;
    logic [63:0] mem_rsp_old = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_code, rsp_acc;
    logic [63:0] rsp_pte;

    int checks = 0, errors = 0;
    bit m_mod = 0, h_mod = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    pte_ad_updater uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Write both enable words; model follows R10.
    task automatic set_env(input bit m, input bit h);
        env_wdata = m ? '1 : '0; env_m_we = 1;
        @(negedge clk); env_m_we = 0;
        m_mod = m; if (!m) h_mod = 0;
        env_wdata = h ? '1 : '0; env_h_we = 1;
        @(negedge clk); env_h_we = 0;
        h_mod = h & m_mod;
        chk(env_m_rdata == (64'(m_mod) << 61), "R10 m_rdata", env_m_rdata, 64'(m_mod) << 61);
        chk(env_h_rdata == (64'(h_mod) << 61), "R10 h_rdata", env_h_rdata, 64'(h_mod) << 61);
    endtask

    task automatic run_op(input logic [63:0] pte, input logic [55:0] addr,
                          input logic [1:0] acc, input logic [1:0] stg,
                          input bit spec, input bit ok, input bit mism, input bit err,
                          input int gd, input int rd, input bit poke);
        bit is_st, need, en, swap, hold, got, granted, answered;
        logic [1:0]  ecode;
        logic [63:0] epte, nw;
        int gc, rc, rsp_k, commit_k, exp_k;
        is_st = (acc == 2'd1);
        need  = !pte[6] || (is_st && !pte[7]);
        en    = (stg == 2'd2) ? h_mod : m_mod;
        nw    = pte | 64'h40 | (is_st ? 64'h80 : 64'h0);
        swap = 0; hold = 0; epte = pte;
        if (!need)     ecode = 2'd0;
        else if (!en)  ecode = 2'd2;
        else if (!ok)  ecode = 2'd3;
        else begin
            swap = 1; hold = is_st && spec;
            if (err)       ecode = 2'd3;
            else if (mism) ecode = 2'd1;
            else begin ecode = 2'd0; epte = nw; end
        end
        req_valid = 1; req_pte = pte; req_addr = addr; req_acc = acc;
        req_stage = stg; req_spec = spec; req_store_ok = ok;
        @(negedge clk);
        req_valid = 0;
        got = 0; granted = 0; answered = 0; gc = 0; rc = 0; rsp_k = -1; commit_k = -1;
        for (int k = 0; k < 40 && !got; k++) begin
            if (rsp_valid) begin
                got = 1;
                exp_k = swap ? rsp_k + 1 : 0;
                chk(k == exp_k, "R6/R11 result cycle", 64'(k), 64'(exp_k));
                chk(rsp_code == ecode, "R1/R2/R3/R4/R6/R7/R8 code", 64'(rsp_code), 64'(ecode));
                chk(rsp_pte == epte, "R1/R6/R7 entry", rsp_pte, epte);
                if (ecode == 2'd3) chk(rsp_acc == acc, "R4/R8 fault access type", 64'(rsp_acc), 64'(acc));
            end else if (!busy) begin
                chk(0, "R11 busy", 64'(busy), 64'd1);
            end
            if (mem_req) begin
                if (!swap) chk(0, "R1/R2/R4 no memory request", 64'(mem_req), 64'd0);
                if (hold && commit_k < 0) chk(0, "R9 request before commit", 64'(mem_req), 64'd0);
                if (!granted && gc == 0) begin
                    chk(mem_addr == addr, "R5 address", 64'(mem_addr), 64'(addr));
                    chk(mem_cmp == pte, "R5 compare", mem_cmp, pte);
                    chk(mem_swap == nw, "R5 swap", mem_swap, nw);
                end
            end
            mem_gnt = 0; mem_rsp_valid = 0; mem_rsp_err = 0; commit = 0;
            if (hold && commit_k < 0 && k == 2) begin commit = 1; commit_k = k; end
            if (mem_req && !granted) begin
                if (gc == gd) begin mem_gnt = 1; granted = 1; end else gc++;
            end else if (granted && !answered) begin
                if (rc == rd) begin
                    mem_rsp_valid = 1; mem_rsp_err = err;
                    mem_rsp_old = mism ? (pte ^ 64'h100) : pte;
                    answered = 1; rsp_k = k;
                end else rc++;
            end
            req_valid = poke && (k == 0);
            if (poke) begin req_pte = ~pte; req_addr = ~addr; req_acc = 2'd1; end
            @(negedge clk);
        end
        req_valid = 0; mem_gnt = 0; mem_rsp_valid = 0; mem_rsp_err = 0; commit = 0;
        chk(got, "R11 result arrives", 64'(got), 64'd1);
        chk(!rsp_valid && !busy, "R11 single result, back to idle", {62'd0, rsp_valid, busy}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !rsp_valid && !mem_req, "R11 reset idle", {61'd0, busy, rsp_valid, mem_req}, 64'd0);
        chk(env_m_rdata == 0 && env_h_rdata == 0, "R10 reset enables", env_m_rdata | env_h_rdata, 64'd0);

        // R10: h write ignored while m clear, and stays clear after m set
        set_env(0, 1);
        env_wdata = '1; env_m_we = 1; @(negedge clk); env_m_we = 0; m_mod = 1;
        chk(env_h_rdata == 0, "R10 h stays clear", env_h_rdata, 64'd0);
        set_env(1, 1);
        set_env(0, 0);

        // R2/R3 directed: both disabled, update needed
        run_op(64'h1, 56'h1000, 2'd0, 2'd0, 0, 1, 0, 0, 0, 0, 0);
        set_env(1, 0);
        // R3: VS stage governed by hypervisor enable (off) -> page fault
        run_op(64'h1, 56'h1008, 2'd0, 2'd2, 0, 1, 0, 0, 0, 0, 0);
        // R3: guest stage uses machine enable -> swap done (R6)
        run_op(64'h1, 56'h1010, 2'd2, 2'd1, 0, 1, 0, 0, 1, 2, 0);
        // R1: flags already set on a store, no update even with enable off
        run_op(64'hC1, 56'h1018, 2'd1, 2'd2, 0, 0, 0, 0, 0, 0, 0);
        // R1: load with A set and D clear passes
        run_op(64'h41, 56'h1020, 2'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
        // R4: store permission check fails
        run_op(64'h41, 56'h1028, 2'd1, 2'd0, 0, 0, 0, 0, 0, 0, 0);
        // R7: mismatch restarts, with a poke while busy (R11)
        run_op(64'h1, 56'h1030, 2'd0, 2'd0, 0, 1, 1, 0, 2, 1, 1);
        // R8: bus error on a fetch
        run_op(64'h1, 56'h1038, 2'd2, 2'd0, 0, 1, 0, 1, 0, 0, 0);
        // R9: speculative store held until commit; speculative load not held
        run_op(64'h41, 56'h1040, 2'd1, 2'd0, 1, 1, 0, 0, 0, 0, 0);
        run_op(64'h1, 56'h1048, 2'd0, 2'd0, 1, 1, 0, 0, 0, 0, 0);
        set_env(1, 1);
        run_op(64'h1, 56'h1050, 2'd1, 2'd2, 0, 1, 0, 0, 0, 3, 0);

        // Constrained random mix
        for (int i = 0; i < 150; i++) begin
            logic [63:0] p;
            if (i % 15 == 0) set_env(1'($urandom), 1'($urandom));
            p = {$urandom, $urandom};
            p[8] = 1'b0;
            run_op(p, 56'({$urandom, $urandom}) & ~56'h7,
                   2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)),
                   1'($urandom), ($urandom_range(0, 3) != 0),
                   ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                   $urandom_range(0, 2), $urandom_range(0, 3), 1'($urandom));
        end
        finish_run();
    end
endmodule